// File: doc/BRIEF.md
# Burst Beat Address Generator

This block takes a single burst command from a memory-mapped address channel and expands it into a stream of beats. The command carries a start address, a beat count, a beat size and a burst kind. Each beat carries the byte address of the transfer and the byte lanes it enables on a 64-bit data path. The block handles three burst kinds: constant-address, incrementing and wrapping. A mode input makes the constant-address kind run as an incrementing burst instead, which suits a memory controller.

While it is idle, the block accepts a command in one cycle. If the command is legal, beats appear on the following cycle. A consumer steps through them with a valid/ready handshake, and the final beat is marked. A command that the block cannot run produces a one-cycle illegal flag and no beats. An incrementing burst whose bytes would run past a 4 KB page is still issued, but every one of its beats carries a page-error flag.

Top module: `burst_addr_gen`

## Requirements
- R1: For an incrementing burst (kind code 1), beat 0 is at the start address and beat n is at the start rounded down to the beat size plus n times the beat size. Beat size in bytes is 2 to the power of the 3-bit size field, and the beat count is the length field plus 1. For example, size 2 from 0x1 gives 0x1, 0x4, 0x8, 0xC.
- R2: For a wrapping burst (kind code 2), the total T is the beat size times the beat count, and the base is the start rounded down to a multiple of T. Each beat address is base + ((start − base + n·size) mod T).
- R3: For a constant-address burst (kind code 0) with the remap input low, every beat has the start address and the same lane mask.
- R4: With `fixed_as_incr` high, a kind 0 command produces exactly the beats of a kind 1 command with the same fields.
- R5: Lane bit i of `beat_strb` is set when i is at least address mod 8 and below ((address rounded down to the beat size) mod 8) plus the beat size.
- R6: `beat_page_err` is high on every beat of an incrementing burst whose last byte, at (start rounded down to size) + count·size − 1, lies in a different 4 KB page than the start. It is low on every other beat.
- R7: The block rejects a command if it is a wrapping burst whose count is not 2, 4, 8 or 16, a wrapping burst whose start is not size-aligned, a command with a size field above 3, or a command of kind code 3. A rejected command raises `cmd_illegal` for exactly the cycle after acceptance and produces no beat.
- R8: `cmd_ready` is high only while no burst is active. A command offered during a burst is ignored and does not change the beats in flight.
- R9: A beat holds its address and lanes while `beat_ready` is low. `beat_last` is high only on the final beat. After the final handshake, `beat_valid` is low and `cmd_ready` is high in the next cycle.
- R10: Reset, even in the middle of a burst, drops `beat_valid` at once and leaves the block idle with `cmd_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fixed_as_incr | input | 1 | Run kind 0 commands as incrementing bursts |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | 3 | Log2 of bytes per beat |
| cmd_kind | input | 2 | Burst kind: 0 constant, 1 incrementing, 2 wrapping |
| cmd_illegal | output | 1 | One-cycle pulse for a rejected command |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_strb | output | 2**LANES_LG2 | Enabled byte lanes |
| beat_last | output | 1 | Final beat of the burst |
| beat_page_err | output | 1 | Burst crosses a 4 KB page |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 8-bit length field, 8 byte lanes and 4 KB pages. The full length field allows a 256-beat incrementing run. The 4 KB page size puts the crossing test at 0xFF8 with one or two 8-byte beats, so both sides of the page boundary can be checked. With 8 lanes, a 16-beat wrap of 8-byte beats covers a 128-byte window that wraps through address zero. The bench inserts ready stalls every third cycle, so it can check that beats hold during a stall.

// File: rtl/bap_pkg.sv
package bap_pkg;
  typedef enum logic [1:0] {
    BK_CONST = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;
endpackage

// File: rtl/bap_rst_sync.sv
module bap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_sync_n = stage[1];
endmodule

// File: rtl/bap_decode.sv
module bap_decode
  import bap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int LANES_LG2 = 3,
  parameter int PAGE_LG2  = 12
) (
  input  logic [PAGE_LG2-1:0] addr_lo,
  input  logic [LEN_W-1:0]    len,
  input  logic [2:0]          size,
  input  logic [1:0]          kind_in,
  input  logic                fixed_as_incr,
  output burst_kind_e         kind,
  output logic                illegal,
  output logic                page_cross,
  output logic [ADDR_W-1:0]   wrap_mask
);
  localparam int PW = PAGE_LG2 + LEN_W + 9;

  logic [PAGE_LG2-1:0] size_lo_mask;
  logic [2:0]          wrap_sh;
  logic                wrap_len_ok;
  logic                wrap_unaligned;
  logic [PW-1:0]       span_end;

  always_comb begin
    size_lo_mask = PAGE_LG2'((PW'(1) << size) - PW'(1));
    kind = burst_kind_e'(kind_in);
    if (kind_in == 2'd0 && fixed_as_incr) kind = BK_INCR;

    wrap_len_ok = 1'b1;
    case (len)
      LEN_W'(1):  wrap_sh = 3'd1;
      LEN_W'(3):  wrap_sh = 3'd2;
      LEN_W'(7):  wrap_sh = 3'd3;
      LEN_W'(15): wrap_sh = 3'd4;
      default: begin
        wrap_sh     = 3'd0;
        wrap_len_ok = 1'b0;
      end
    endcase
    wrap_mask      = ((ADDR_W'(1) << size) << wrap_sh) - ADDR_W'(1);
    wrap_unaligned = (addr_lo & size_lo_mask) != '0;

    illegal = (size > 3'(LANES_LG2)) || (kind == BK_RSVD) ||
              ((kind == BK_WRAP) && (!wrap_len_ok || wrap_unaligned));

    span_end   = PW'(addr_lo & ~size_lo_mask) + ((PW'(len) + PW'(1)) << size);
    page_cross = !illegal && (kind == BK_INCR) && (span_end > (PW'(1) << PAGE_LG2));
  end
endmodule

// File: rtl/bap_lanes.sv
module bap_lanes #(
  parameter int LANES_LG2 = 3
) (
  input  logic [LANES_LG2-1:0]    addr_lo,
  input  logic [2:0]              size,
  output logic [2**LANES_LG2-1:0] strb
);
  localparam int LANES = 2**LANES_LG2;

  logic [LANES_LG2:0] beat_bytes;
  logic [LANES_LG2:0] lane_end;

  always_comb begin
    beat_bytes = (LANES_LG2+1)'(1) << size;
    lane_end   = {1'b0, addr_lo & ~LANES_LG2'(beat_bytes - 1'b1)} + beat_bytes;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strb[i] = ((LANES_LG2+1)'(i) >= {1'b0, addr_lo}) &&
                     ((LANES_LG2+1)'(i) < lane_end);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int LANES_LG2 = 3,
  parameter int PAGE_LG2  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fixed_as_incr,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LEN_W-1:0]        cmd_len,
  input  logic [2:0]              cmd_size,
  input  logic [1:0]              cmd_kind,
  output logic                    cmd_illegal,
  output logic                    beat_valid,
  input  logic                    beat_ready,
  output logic [ADDR_W-1:0]       beat_addr,
  output logic [2**LANES_LG2-1:0] beat_strb,
  output logic                    beat_last,
  output logic                    beat_page_err
);
  logic rst_sync_n;

  bap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  burst_kind_e       dec_kind;
  logic              dec_illegal, dec_cross;
  logic [ADDR_W-1:0] dec_wmask;

  bap_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES_LG2(LANES_LG2), .PAGE_LG2(PAGE_LG2)) u_dec (
    .addr_lo(cmd_addr[PAGE_LG2-1:0]), .len(cmd_len), .size(cmd_size), .kind_in(cmd_kind),
    .fixed_as_incr(fixed_as_incr), .kind(dec_kind), .illegal(dec_illegal),
    .page_cross(dec_cross), .wrap_mask(dec_wmask)
  );

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [2:0]        size_q, size_d;
  burst_kind_e       kind_q, kind_d;
  logic [ADDR_W-1:0] wmask_q, wmask_d;
  logic              page_q, page_d;
  logic              ill_q, ill_d;
  logic              accept, step, state_en;
  logic [ADDR_W-1:0] bytes_q, next_addr;

  assign accept   = cmd_valid && !busy_q;
  assign step     = busy_q && beat_ready;
  assign state_en = accept || step;

  always_comb begin
    bytes_q = ADDR_W'(1) << size_q;
    case (kind_q)
      BK_INCR: next_addr = (addr_q & ~(bytes_q - ADDR_W'(1))) + bytes_q;
      BK_WRAP: next_addr = (addr_q & ~wmask_q) | ((addr_q + bytes_q) & wmask_q);
      default: next_addr = addr_q;
    endcase
  end

  always_comb begin
    busy_d  = busy_q;
    addr_d  = addr_q;
    left_d  = left_q;
    size_d  = size_q;
    kind_d  = kind_q;
    wmask_d = wmask_q;
    page_d  = page_q;
    ill_d   = 1'b0;
    if (accept) begin
      if (dec_illegal) begin
        ill_d = 1'b1;
      end else begin
        busy_d  = 1'b1;
        addr_d  = cmd_addr;
        left_d  = cmd_len;
        size_d  = cmd_size;
        kind_d  = dec_kind;
        wmask_d = dec_wmask;
        page_d  = dec_cross;
      end
    end else if (step) begin
      if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        left_d = left_q - LEN_W'(1);
        addr_d = next_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      size_q  <= '0;
      kind_q  <= BK_CONST;
      wmask_q <= '0;
      page_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      ill_q <= ill_d;
      if (state_en) begin
        busy_q  <= busy_d;
        addr_q  <= addr_d;
        left_q  <= left_d;
        size_q  <= size_d;
        kind_q  <= kind_d;
        wmask_q <= wmask_d;
        page_q  <= page_d;
      end
    end
  end

  bap_lanes #(.LANES_LG2(LANES_LG2)) u_lanes (
    .addr_lo(addr_q[LANES_LG2-1:0]), .size(size_q), .strb(beat_strb)
  );

  assign cmd_ready     = !busy_q;
  assign cmd_illegal   = ill_q;
  assign beat_valid    = busy_q;
  assign beat_addr     = addr_q;
  assign beat_last     = busy_q && (left_q == '0);
  assign beat_page_err = busy_q && page_q;

  // R9: a stalled beat keeps its address and lanes
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_strb));

  // R9: back to idle right after the final handshake
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid && cmd_ready);

  // R7: a rejected command issues nothing
  a_r7_no_issue: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_illegal |-> !beat_valid);

  // R3: constant-address bursts never move
  a_r3_const_addr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_ready && !beat_last && kind_q == BK_CONST |=> $stable(beat_addr));

  // R1: beats after the first are size-aligned
  a_r1_incr_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_ready && !beat_last && kind_q == BK_INCR |=>
      (beat_addr & ((ADDR_W'(1) << size_q) - ADDR_W'(1))) == '0);

  // R5: an issued beat always enables at least one lane
  a_r5_lane_present: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid |-> beat_strb != '0);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_as_incr = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_kind = '0;
  logic        cmd_illegal;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [7:0]  beat_strb;
  logic        beat_last;
  logic        beat_page_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .fixed_as_incr(fixed_as_incr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_kind(cmd_kind),
    .cmd_illegal(cmd_illegal), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last),
    .beat_page_err(beat_page_err)
  );

  // {remap, kind, size, len, addr, expect_illegal, expect_page}
  localparam int NV = 12;
  localparam logic [47:0] VECS [NV] = '{
    {1'b0, 2'd1, 3'd2, 8'd3,   32'h0000_0001, 1'b0, 1'b0},
    {1'b0, 2'd2, 3'd2, 8'd3,   32'h0000_0018, 1'b0, 1'b0},
    {1'b0, 2'd0, 3'd3, 8'd2,   32'h0000_0040, 1'b0, 1'b0},
    {1'b1, 2'd0, 3'd1, 8'd2,   32'h0000_0103, 1'b0, 1'b0},
    {1'b0, 2'd1, 3'd3, 8'd1,   32'h0000_0FF8, 1'b0, 1'b1},
    {1'b0, 2'd1, 3'd3, 8'd0,   32'h0000_0FF8, 1'b0, 1'b0},
    {1'b0, 2'd2, 3'd2, 8'd2,   32'h0000_0020, 1'b1, 1'b0},
    {1'b0, 2'd2, 3'd2, 8'd3,   32'h0000_001A, 1'b1, 1'b0},
    {1'b0, 2'd1, 3'd4, 8'd0,   32'h0000_0000, 1'b1, 1'b0},
    {1'b0, 2'd1, 3'd0, 8'd255, 32'h0000_0000, 1'b0, 1'b0},
    {1'b0, 2'd2, 3'd3, 8'd15,  32'h0000_0038, 1'b0, 1'b0},
    {1'b0, 2'd3, 3'd2, 8'd0,   32'h0000_0000, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned model_addr(input int unsigned a, input int sz,
                                             input int kind, input int len, input int n);
    int unsigned sb = 1 << sz;
    int unsigned tot = sb * (len + 1);
    int unsigned base = (a / tot) * tot;
    if (kind == 0) return a;
    if (kind == 1) return (n == 0) ? a : (a / sb) * sb + n * sb;
    return base + ((a - base) + n * sb) % tot;
  endfunction

  function automatic logic [7:0] model_strb(input int unsigned a, input int sz);
    int unsigned sb = 1 << sz;
    int unsigned lo = a % 8;
    int unsigned hi = ((a / sb) * sb) % 8 + sb;
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_vec(input int idx);
    logic [47:0] v = VECS[idx];
    bit mode = v[47];
    int kind = int'(v[46:45]);
    int sz = int'(v[44:42]);
    int len = int'(v[41:34]);
    int unsigned a = v[33:2];
    bit ill = v[1];
    bit pg = v[0];
    int eff = (kind == 0 && mode) ? 1 : kind;
    int n = 0;
    int k = 0;
    bit hs;
    logic [7:0] first_strb = '0;
    @(negedge clk);
    fixed_as_incr = mode; cmd_kind = 2'(kind); cmd_size = 3'(sz);
    cmd_len = 8'(len); cmd_addr = a; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ill) begin
      chk(cmd_illegal === 1'b1, "R7", $sformatf("vec%0d illegal flag", idx), cmd_illegal, 1);
      chk(beat_valid === 1'b0, "R7", $sformatf("vec%0d no beat", idx), beat_valid, 0);
      @(negedge clk);
      chk(cmd_illegal === 1'b0 && beat_valid === 1'b0, "R7",
          $sformatf("vec%0d single pulse", idx), {cmd_illegal, beat_valid}, 0);
      return;
    end
    while (n <= len && k < 2000) begin
      int unsigned ea = model_addr(a, sz, eff, len, n);
      beat_ready = (k % 3) != 1;
      chk(beat_valid === 1'b1, "R9", $sformatf("vec%0d beat%0d valid", idx, n), beat_valid, 1);
      chk(beat_addr === ea, (eff == 2) ? "R2" : (eff == 0) ? "R3" : (kind == 0) ? "R4" : "R1",
          $sformatf("vec%0d beat%0d addr", idx, n), beat_addr, ea);
      chk(beat_strb === model_strb(ea, sz), "R5", $sformatf("vec%0d beat%0d lanes", idx, n),
          beat_strb, model_strb(ea, sz));
      if (n == 0) first_strb = beat_strb;
      if (eff == 0)
        chk(beat_strb === first_strb, "R3", $sformatf("vec%0d beat%0d same lanes", idx, n),
            beat_strb, first_strb);
      chk(beat_last === (n == len), "R9", $sformatf("vec%0d beat%0d last", idx, n),
          beat_last, (n == len));
      chk(beat_page_err === pg, "R6", $sformatf("vec%0d beat%0d page", idx, n), beat_page_err, pg);
      hs = beat_valid && beat_ready;
      @(posedge clk);
      @(negedge clk);
      if (hs) n++;
      k++;
    end
    beat_ready = 1'b0;
    chk(beat_valid === 1'b0 && cmd_ready === 1'b1, "R9", $sformatf("vec%0d idle after last", idx),
        {beat_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(cmd_ready === 1'b1 && beat_valid === 1'b0 && cmd_illegal === 1'b0, "R10",
        "reset state", {cmd_ready, beat_valid, cmd_illegal}, 3'b100);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8: command offered during a burst is ignored
    @(negedge clk);
    fixed_as_incr = 1'b0; cmd_kind = 2'd1; cmd_size = 3'd3; cmd_len = 8'd3;
    cmd_addr = 32'h200; cmd_valid = 1'b1; beat_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_addr = 32'h800; cmd_len = 8'd0;
    chk(cmd_ready === 1'b0, "R8", "ready low while busy", cmd_ready, 0);
    repeat (3) @(negedge clk);
    chk(beat_addr === 32'h200, "R8", "busy command ignored", beat_addr, 32'h200);
    chk(beat_last === 1'b0, "R8", "length not replaced", beat_last, 0);
    cmd_valid = 1'b0;
    beat_ready = 1'b1;
    @(negedge clk);
    chk(beat_addr === 32'h208, "R8", "burst continues", beat_addr, 32'h208);

    // R10: reset in the middle of the burst
    beat_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(beat_valid === 1'b0, "R10", "reset drops valid", beat_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready === 1'b1 && beat_valid === 1'b0, "R10", "idle after reset",
        {cmd_ready, beat_valid}, 2'b10);

    report();
  end
endmodule